// File: doc/BRIEF.md
# Configurable Digital Channel I/O Matrix

This block manages a bank of general-purpose digital channels. The direction of each channel is set on its own: it is either sampled as an input or driven as an output. A sampled input first crosses a synchroniser. A per-channel polarity mask can then flip it, and a per-channel mask can route it through a glitch filter. The resulting conditioned value is presented for reading on a parallel port.

Each output channel takes its level from one of three sources. The first is a programmed static level. The second is a registered logical reduction (AND, OR, XOR or NOR) over a chosen group of conditioned input channels. The third is an external PWM stream. All settings are written through a simple write-only configuration port that has eight word-wide registers.

Top module: `dio_matrix`

## Requirements
- R1: After reset every channel is an input: `pad_oe` and `pad_out` are all zero, and `in_value` is zero while `pad_in` is zero.
- R2: Configuration address 0 holds the direction mask (bit set = output). `pad_oe` equals that mask from the clock edge that writes it.
- R3: Address 1 holds the polarity mask. A set bit inverts that channel's synchronised input before filtering and reading.
- R4: Address 2 holds the filter mask. On a filtered channel the conditioned value changes only after the synchronised input has differed from it for FILT_LEN (default 4) consecutive clock edges. A shorter pulse never reaches `in_value`.
- R5: On an unfiltered channel, a `pad_in` change that is sampled at clock edge N appears on `in_value` after edge N+1 (a two-stage synchroniser).
- R6: Address 7 bits [1:0] pick the reduction: 0 = AND, 1 = OR, 2 = XOR, 3 = NOR. Address 6 is the operand mask. Only channels that are configured as inputs and are set in the operand mask take part.
- R7: When no input channel is selected as an operand, the reduction result is 0 for every operation code. Output channels set in the operand mask are not counted.
- R8: The reduction result reaches `pad_out` exactly one clock edge after the conditioned inputs change.
- R9: Address 5 (PWM select) and address 4 (reduction select) choose the source of each output channel. PWM select wins over reduction select. A channel with neither bit set drives its bit of the static level register at address 3. A PWM-driven channel follows `pwm_in` without a register.
- R10: An input channel drives `pad_out` low whatever its source settings are. Those settings take effect as soon as the channel is made an output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | NCH (32) | Configuration write data |
| pad_in | input | NCH (32) | Raw channel levels from the pads |
| pwm_in | input | 1 | External PWM stream |
| pad_oe | output | NCH (32) | Output enable per channel |
| pad_out | output | NCH (32) | Driven level per channel |
| in_value | output | NCH (32) | Conditioned input levels |

## Verification
The reduction is driven from a vector table. For each of the four operation codes it gets one pattern that should give 1 and one that should give 0, so a swapped or mis-decoded code shows up. Further vectors cover an empty operand mask under AND and NOR, a mask that holds only an output channel, an operand list mixed with an output channel that must be dropped, and a 31-input XOR with odd parity. Directed cases then count edges to pin down the synchroniser and reduction latency. They drive a step and a three-cycle glitch into a filtered channel, and they check source priority and the silencing of input channels.

// File: rtl/dio_pkg.sv
package dio_pkg;

   typedef enum logic [1:0] {
      OP_AND = 2'd0,
      OP_OR  = 2'd1,
      OP_XOR = 2'd2,
      OP_NOR = 2'd3
   } redop_e;

   typedef enum logic [2:0] {
      CFG_DIR  = 3'd0,
      CFG_POL  = 3'd1,
      CFG_FILT = 3'd2,
      CFG_LVL  = 3'd3,
      CFG_RSEL = 3'd4,
      CFG_PSEL = 3'd5,
      CFG_OPND = 3'd6,
      CFG_OP   = 3'd7
   } cfgreg_e;

endpackage

// File: rtl/dio_sync.sv
module dio_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/dio_glitch_filter.sv
module dio_glitch_filter #(
   parameter int LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   localparam int CW = (LEN > 2) ? $clog2(LEN) : 1;
   localparam logic [CW-1:0] CNT_LAST = CW'(LEN - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout <= 1'b0;
         cnt  <= '0;
      end else if (din == dout) begin
         cnt  <= '0;
      end else if (cnt == CNT_LAST) begin
         dout <= din;
         cnt  <= '0;
      end else begin
         cnt  <= cnt + 1'b1;
      end
   end

   AST_FLT_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_LAST);                                             // R4

   AST_FLT_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
      (dout != $past(dout)) |-> ($past(din) == dout));              // R4

   AST_FLT_NO_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
      (dout != $past(dout)) |-> ($past(cnt) == CNT_LAST));          // R4

endmodule

// File: rtl/dio_reduce.sv
module dio_reduce
   import dio_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] val,
   input  logic [W-1:0] opnd,
   input  redop_e       op,
   output logic         res
);

   logic res_d;
   logic empty;

   assign empty = ~|opnd;

   always_comb begin
      unique case (op)
         OP_AND:  res_d = &(val | ~opnd);
         OP_OR:   res_d = |(val & opnd);
         OP_XOR:  res_d = ^(val & opnd);
         default: res_d = ~|(val & opnd);
      endcase
      if (empty) res_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) res <= 1'b0;
      else        res <= res_d;
   end

   AST_RED_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(opnd) == '0) |-> !res);                                // R7

   AST_RED_OR_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(op) == OP_OR && $past(|(val & opnd))) |-> res);        // R6

   AST_RED_NOR_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(op) == OP_NOR && $past(|(val & opnd))) |-> !res);      // R6

endmodule

// File: rtl/dio_matrix.sv
module dio_matrix
   import dio_pkg::*;
#(
   parameter int NCH         = 32,
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cfg_we,
   input  logic [2:0]     cfg_addr,
   input  logic [NCH-1:0] cfg_wdata,
   input  logic [NCH-1:0] pad_in,
   input  logic           pwm_in,
   output logic [NCH-1:0] pad_oe,
   output logic [NCH-1:0] pad_out,
   output logic [NCH-1:0] in_value
);

   if (NCH < 2) begin : g_bad_nch
      $error("dio_matrix: NCH must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("dio_matrix: SYNC_STAGES must be at least 2");
   end
   if (FILT_LEN < 2) begin : g_bad_filt
      $error("dio_matrix: FILT_LEN must be at least 2");
   end

   logic [NCH-1:0] dir_q, pol_q, filt_q, lvl_q, rsel_q, psel_q, opnd_q;
   redop_e         op_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '0;
         pol_q  <= '0;
         filt_q <= '0;
         lvl_q  <= '0;
         rsel_q <= '0;
         psel_q <= '0;
         opnd_q <= '0;
         op_q   <= OP_AND;
      end else if (cfg_we) begin
         unique case (cfgreg_e'(cfg_addr))
            CFG_DIR:  dir_q  <= cfg_wdata;
            CFG_POL:  pol_q  <= cfg_wdata;
            CFG_FILT: filt_q <= cfg_wdata;
            CFG_LVL:  lvl_q  <= cfg_wdata;
            CFG_RSEL: rsel_q <= cfg_wdata;
            CFG_PSEL: psel_q <= cfg_wdata;
            CFG_OPND: opnd_q <= cfg_wdata;
            default:  op_q   <= redop_e'(cfg_wdata[1:0]);
         endcase
      end
   end

   logic [NCH-1:0] synced, polar, filtered, cond;

   dio_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (synced)
   );

   assign polar = synced ^ pol_q;

   for (genvar i = 0; i < NCH; i++) begin : g_in
      dio_glitch_filter #(.LEN(FILT_LEN)) u_filt (
         .clk   (clk),
         .rst_n (rst_n),
         .din   (polar[i]),
         .dout  (filtered[i])
      );
      assign cond[i] = filt_q[i] ? filtered[i] : polar[i];
   end

   assign in_value = cond;

   logic red_res;

   dio_reduce #(.W(NCH)) u_reduce (
      .clk   (clk),
      .rst_n (rst_n),
      .val   (cond),
      .opnd  (opnd_q & ~dir_q),
      .op    (op_q),
      .res   (red_res)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_out
      logic src;
      always_comb begin
         if (psel_q[i])      src = pwm_in;
         else if (rsel_q[i]) src = red_res;
         else                src = lvl_q[i];
      end
      assign pad_out[i] = dir_q[i] & src;

      AST_IN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         !pad_oe[i] |-> !pad_out[i]);                               // R10
   end

   assign pad_oe = dir_q;

   AST_OE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == 3'd0) |=> (pad_oe == $past(cfg_wdata))); // R2

endmodule

// File: tb/dio_matrix_tb.sv
module dio_matrix_tb;

   localparam int CLK_PERIOD = 20;
   localparam int NCH = 32;
   localparam int NVEC = 13;

   typedef struct packed {
      logic [1:0]  op;
      logic [31:0] mask;
      logic [31:0] pins;
      logic        exp;
   } vec_t;

   localparam vec_t VECS [NVEC] = '{
      '{2'd0, 32'h0000_000F, 32'h0000_000F, 1'b1},
      '{2'd0, 32'h0000_000F, 32'h0000_0007, 1'b0},
      '{2'd1, 32'h0000_00F0, 32'h0000_0010, 1'b1},
      '{2'd1, 32'h0000_00F0, 32'h0000_000F, 1'b0},
      '{2'd2, 32'h0000_00FF, 32'h0000_0007, 1'b1},
      '{2'd2, 32'h0000_00FF, 32'h0000_0003, 1'b0},
      '{2'd3, 32'h0000_FF00, 32'h0000_00FF, 1'b1},
      '{2'd3, 32'h0000_FF00, 32'h0000_0100, 1'b0},
      '{2'd0, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0},
      '{2'd3, 32'h0000_0000, 32'h0000_0000, 1'b0},
      '{2'd0, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0},
      '{2'd0, 32'h8000_0001, 32'h0000_0001, 1'b1},
      '{2'd2, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1}
   };

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           cfg_we = 1'b0;
   logic [2:0]     cfg_addr = '0;
   logic [NCH-1:0] cfg_wdata = '0;
   logic [NCH-1:0] pad_in = '0;
   logic           pwm_in = 1'b0;
   logic [NCH-1:0] pad_oe, pad_out, in_value;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dio_matrix #(.NCH(NCH)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .pad_in    (pad_in),
      .pwm_in    (pwm_in),
      .pad_oe    (pad_oe),
      .pad_out   (pad_out),
      .in_value  (in_value)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cfg_wr(logic [2:0] a, logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_addr = a;
      cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic wait_n(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      wait_n(3);
      rst_n = 1'b1;
      wait_n(1);
      // R1 reset state
      chk("R1 oe", pad_oe, 32'h0);
      chk("R1 out", pad_out, 32'h0);
      chk("R1 in_value", in_value, 32'h0);

      // R5 synchroniser latency
      pad_in = 32'h0000_0005;
      wait_n(1);
      chk("R5 not yet", in_value, 32'h0);
      wait_n(1);
      chk("R5 arrived", in_value, 32'h0000_0005);

      // R3 polarity
      pad_in = 32'h0000_0001;
      wait_n(3);
      cfg_wr(3'd1, 32'h0000_0003);
      chk("R3 inverted", {28'h0, in_value[3:0]}, 32'h2);
      cfg_wr(3'd1, 32'h0);

      // R6 R7 reduction table, channel 31 output fed by reduction
      cfg_wr(3'd0, 32'h8000_0000);
      cfg_wr(3'd4, 32'h8000_0000);
      for (int k = 0; k < NVEC; k++) begin
         cfg_wr(3'd7, {30'h0, VECS[k].op});
         cfg_wr(3'd6, VECS[k].mask);
         @(negedge clk);
         pad_in = VECS[k].pins;
         wait_n(4);
         chk($sformatf("R6/R7 vec %0d", k), {31'h0, pad_out[31]}, {31'h0, VECS[k].exp});
         chk($sformatf("R5 vec %0d in", k), {1'b0, in_value[30:0]}, {1'b0, VECS[k].pins[30:0]});
      end

      // R8 reduction latency: OR over channel 0
      cfg_wr(3'd7, 32'd1);
      cfg_wr(3'd6, 32'h0000_0001);
      pad_in = 32'h0;
      wait_n(4);
      chk("R8 idle", {31'h0, pad_out[31]}, 32'h0);
      pad_in = 32'h0000_0001;
      wait_n(2);
      chk("R8 cond ready", {31'h0, in_value[0]}, 32'h1);
      chk("R8 one edge later", {31'h0, pad_out[31]}, 32'h0);
      wait_n(1);
      chk("R8 result out", {31'h0, pad_out[31]}, 32'h1);

      // R2 R9 direction and static level
      cfg_wr(3'd4, 32'h0);
      cfg_wr(3'd6, 32'h0);
      cfg_wr(3'd3, 32'h0000_00B0);
      cfg_wr(3'd0, 32'h0000_00F0);
      chk("R2 oe", pad_oe, 32'h0000_00F0);
      chk("R9 static", pad_out, 32'h0000_00B0);

      // R9 PWM beats reduction beats static
      cfg_wr(3'd5, 32'h0000_0010);
      cfg_wr(3'd4, 32'h0000_0010);
      pwm_in = 1'b1;
      wait_n(1);
      chk("R9 pwm high", {31'h0, pad_out[4]}, 32'h1);
      pwm_in = 1'b0;
      wait_n(1);
      chk("R9 pwm low", {31'h0, pad_out[4]}, 32'h0);
      pwm_in = 1'b1;
      cfg_wr(3'd5, 32'h0);
      chk("R9 reduction over static", {31'h0, pad_out[4]}, 32'h0);
      cfg_wr(3'd4, 32'h0);
      chk("R9 static fallback", {31'h0, pad_out[4]}, 32'h1);

      // R10 input channel stays silent, then takes effect
      cfg_wr(3'd3, 32'h0000_00B4);
      cfg_wr(3'd5, 32'h0000_0014);
      chk("R10 input quiet", {31'h0, pad_out[2]}, 32'h0);
      chk("R10 input oe", {31'h0, pad_oe[2]}, 32'h0);
      cfg_wr(3'd0, 32'h0000_00F4);
      chk("R10 switched to output", {31'h0, pad_out[2]}, 32'h1);

      // R4 glitch filter on channel 8, channel 9 unfiltered
      cfg_wr(3'd0, 32'h0);
      cfg_wr(3'd5, 32'h0);
      pad_in = 32'h0;
      wait_n(8);
      cfg_wr(3'd2, 32'h0000_0100);
      pad_in = 32'h0000_0300;
      wait_n(2);
      chk("R5 unfiltered ch9", {31'h0, in_value[9]}, 32'h1);
      chk("R4 filtered ch8 held", {31'h0, in_value[8]}, 32'h0);
      wait_n(3);
      chk("R4 one edge short", {31'h0, in_value[8]}, 32'h0);
      wait_n(1);
      chk("R4 accepted", {31'h0, in_value[8]}, 32'h1);
      pad_in = 32'h0000_0200;
      wait_n(3);
      pad_in = 32'h0000_0300;
      wait_n(8);
      chk("R4 glitch rejected", {31'h0, in_value[8]}, 32'h1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule